// File: doc/BRIEF.md
# Bloom-Filter Sharer Directory Array

This block is the storage and lookup core of a tagless coherence directory for a multiprocessor whose cores have private caches. It does not keep address tags. Instead it holds K hash tables. Each table has one row of buckets for each cache set, and every bucket holds a P-bit sharing vector with one bit per core. A block address is split into a set index and a tag. Each table picks one bucket in the block's set with its own hash of the tag. A lookup returns the bitwise AND of the K selected vectors. The result is a conservative sharer set: a zero bit proves that the core does not cache the block, and a one bit means the core may cache it.

The directory controller calls the block with two kinds of traffic. The first is lookups, which use a valid/ready handshake and have a fixed two-cycle latency. The second is single-cycle updates. An insert records that a core has filled the block. A clear records an eviction or an invalidation. It removes the core only from the tables that a per-table mask names, so that bits still needed by other blocks of the same set stay set. The protocol sequencing that decides the mask and the order of requests lies outside this block. The defaults are a scaled-down geometry. The full-size geometry of 1024 sets and 64 buckets is reached by changing parameters only.

Top module: `dir_bloom_directory`

## Requirements
- R1: While reset is held, `lkReady` and `rsValid` are 0. After reset every vector in every table is zero, so any lookup returns all zeros, and `lkReady` is 1 from the first cycle after reset is released.
- R2: A lookup is accepted on a rising edge where `lkValid` and `lkReady` are both 1. `rsValid` is 1 exactly two rising edges later, for one cycle per accepted lookup. `rsValid` is never 1 without such an acceptance. Back-to-back lookups are accepted in every cycle.
- R3: `rsSharers` equals the bitwise AND of the K vectors selected by the looked-up address, one vector from each table.
- R4: The address bits [OFF_W-1:0] are ignored. The set index is bits [OFF_W+SET_W-1:OFF_W] and the tag is the bits above them. With the default `HASH_SEL`, table 0 uses tag[m-1:0], table 1 uses tag[m+2:3], table 2 uses tag[m+5:6], and table 3 uses the low m bits of (lower tag half XOR upper tag half). Here m = log2(BUCKETS). With the default 38-bit tag, the value for table 3 is tag[3:0] ^ tag[22:19].
- R5: An update with `updValid`=1 and `updOp`=0 (insert) sets bit `updCore` in the selected vector of every table, whatever `updMask` holds.
- R6: An update with `updOp`=1 (clear) resets bit `updCore` only in the tables whose `updMask` bit is 1, where bit i names table i. A mask of zero changes nothing.
- R7: An update presented in the same cycle as an accepted lookup is visible in that lookup's result. An update presented in the following cycle is not visible.
- R8: Addresses with the same tag in different sets use separate vectors, so an insert in one set is never visible to a lookup in another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request valid |
| lkReady | output | 1 | Lookup can be accepted |
| lkAddr | input | ADDR_W | Physical address to look up |
| rsValid | output | 1 | Lookup result valid |
| rsSharers | output | P | Potential-sharer vector, bit c for core c |
| updValid | input | 1 | Update valid this cycle |
| updOp | input | 1 | 0 = insert, 1 = clear |
| updAddr | input | ADDR_W | Address of the updated block |
| updCore | input | log2(P) | Core whose bit is changed |
| updMask | input | K | For a clear, the tables that may reset their bit |

## Verification
The assertions assume that `updCore` is always below P. They also assume that a lookup and an update to the same address in the same cycle follow the rule of R7: the update first, then the read. The stimulus keeps `updCore` in range by drawing it modulo P. It draws addresses from a small pool of tags over a few sets, so that inserts, clears and lookups of the same block and of aliasing blocks collide often. Directed steps add the same-cycle and next-cycle update cases. They also add tags that differ only in bits that no hash reads, or only in bits that the XOR fold reads.

// File: rtl/dir_bloom_pkg.sv
package dir_bloom_pkg;

  // Selector code that picks the folded-XOR hash for a table.
  localparam logic [7:0] HASH_XOR = 8'hFF;

  typedef enum logic {
    UPD_INSERT = 1'b0,
    UPD_CLEAR  = 1'b1
  } updOp_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;  // latch the lookup indices
    logic resolve;  // read the tables and register the AND
    logic write;    // apply the update this edge
    logic clearOp;  // update is a clear, not an insert
  } dirStrobe_t;

endpackage

// File: rtl/dir_bloom_ctrl.sv
module dir_bloom_ctrl
  import dir_bloom_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lkValid,
  input  logic       updValid,
  input  logic       updOp,
  output logic       lkReady,
  output logic       rsValid,
  output dirStrobe_t strobe
);

  logic readyQ;
  logic stage1Valid;
  logic resultValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ      <= 1'b0;
      stage1Valid <= 1'b0;
      resultValid <= 1'b0;
    end else begin
      readyQ      <= 1'b1;
      stage1Valid <= lkValid && readyQ;
      resultValid <= stage1Valid;
    end
  end

  always_comb begin
    strobe.capture = lkValid && readyQ;
    strobe.resolve = stage1Valid;
    strobe.write   = updValid && rstN;
    strobe.clearOp = (updOp_e'(updOp) == UPD_CLEAR);
  end

  assign lkReady = readyQ;
  assign rsValid = resultValid;

endmodule

// File: rtl/dir_bloom_datapath.sv
module dir_bloom_datapath
  import dir_bloom_pkg::*;
#(
  parameter int unsigned      P         = 16,
  parameter int unsigned      K         = 4,
  parameter int unsigned      SETS      = 16,
  parameter int unsigned      BUCKETS   = 16,
  parameter int unsigned      ADDR_W    = 48,
  parameter int unsigned      BLK_BYTES = 64,
  parameter logic [K*8-1:0]   HASH_SEL  = {8'hFF, 8'd6, 8'd3, 8'd0}
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dirStrobe_t               strobe,
  input  logic [ADDR_W-1:0]        lkAddr,
  input  logic [ADDR_W-1:0]        updAddr,
  input  logic [$clog2(P)-1:0]     updCore,
  input  logic [K-1:0]             updMask,
  output logic [P-1:0]             rsSharers
);

  localparam int unsigned SET_W   = $clog2(SETS);
  localparam int unsigned BKT_W   = $clog2(BUCKETS);
  localparam int unsigned OFF_W   = $clog2(BLK_BYTES);
  localparam int unsigned TAG_W   = ADDR_W - OFF_W - SET_W;
  localparam int unsigned HALF_W  = TAG_W / 2;
  localparam int unsigned IDX_W   = SET_W + BKT_W;
  localparam int unsigned ENTRIES = SETS * BUCKETS;

  function automatic logic [BKT_W-1:0] hashBucket(input logic [TAG_W-1:0] tag,
                                                  input logic [7:0] sel);
    logic [TAG_W-1:0] mixed;
    if (sel == HASH_XOR) mixed = tag ^ (tag >> HALF_W);
    else                 mixed = tag >> sel;
    return mixed[BKT_W-1:0];
  endfunction

  logic [SET_W-1:0] lkSet, updSet;
  logic [TAG_W-1:0] lkTag, updTag;

  assign lkSet  = lkAddr[OFF_W +: SET_W];
  assign lkTag  = lkAddr[OFF_W+SET_W +: TAG_W];
  assign updSet = updAddr[OFF_W +: SET_W];
  assign updTag = updAddr[OFF_W+SET_W +: TAG_W];

  logic [P-1:0] tableVec [K];

  for (genvar t = 0; t < K; t++) begin : g_table
    logic [P-1:0]     vecMem [ENTRIES];
    logic [IDX_W-1:0] lkIdx, updIdx, heldIdx;

    assign lkIdx  = {lkSet,  hashBucket(lkTag,  HASH_SEL[t*8 +: 8])};
    assign updIdx = {updSet, hashBucket(updTag, HASH_SEL[t*8 +: 8])};

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int e = 0; e < ENTRIES; e++) vecMem[e] <= '0;
        heldIdx <= '0;
      end else begin
        if (strobe.capture) heldIdx <= lkIdx;
        if (strobe.write) begin
          if (!strobe.clearOp)  vecMem[updIdx][updCore] <= 1'b1;
          else if (updMask[t])  vecMem[updIdx][updCore] <= 1'b0;
        end
      end
    end

    assign tableVec[t] = vecMem[heldIdx];
  end

  logic [P-1:0] andVec;

  always_comb begin
    andVec = '1;
    for (int t = 0; t < K; t++) andVec &= tableVec[t];
  end

  always_ff @(posedge clk) begin
    if (!rstN)               rsSharers <= '0;
    else if (strobe.resolve) rsSharers <= andVec;
  end

endmodule

// File: rtl/dir_bloom_directory.sv
module dir_bloom_directory
  import dir_bloom_pkg::*;
#(
  parameter int unsigned      P         = 16,
  parameter int unsigned      K         = 4,
  parameter int unsigned      SETS      = 16,
  parameter int unsigned      BUCKETS   = 16,
  parameter int unsigned      ADDR_W    = 48,
  parameter int unsigned      BLK_BYTES = 64,
  parameter logic [K*8-1:0]   HASH_SEL  = {8'hFF, 8'd6, 8'd3, 8'd0}
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  lkValid,
  output logic                  lkReady,
  input  logic [ADDR_W-1:0]     lkAddr,
  output logic                  rsValid,
  output logic [P-1:0]          rsSharers,
  input  logic                  updValid,
  input  logic                  updOp,
  input  logic [ADDR_W-1:0]     updAddr,
  input  logic [$clog2(P)-1:0]  updCore,
  input  logic [K-1:0]          updMask
);

  dirStrobe_t strobe;

  dir_bloom_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .lkValid  (lkValid),
    .updValid (updValid),
    .updOp    (updOp),
    .lkReady  (lkReady),
    .rsValid  (rsValid),
    .strobe   (strobe)
  );

  dir_bloom_datapath #(
    .P(P), .K(K), .SETS(SETS), .BUCKETS(BUCKETS),
    .ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES), .HASH_SEL(HASH_SEL)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .lkAddr    (lkAddr),
    .updAddr   (updAddr),
    .updCore   (updCore),
    .updMask   (updMask),
    .rsSharers (rsSharers)
  );

endmodule

// File: rtl/dir_bloom_checker.sv
module dir_bloom_checker #(
  parameter int unsigned      P         = 16,
  parameter int unsigned      K         = 4,
  parameter int unsigned      ADDR_W    = 48
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  lkValid,
  input logic                  lkReady,
  input logic [ADDR_W-1:0]     lkAddr,
  input logic                  rsValid,
  input logic [P-1:0]          rsSharers,
  input logic                  updValid,
  input logic                  updOp,
  input logic [ADDR_W-1:0]     updAddr,
  input logic [$clog2(P)-1:0]  updCore,
  input logic [K-1:0]          updMask
);

  // R1: no handshake activity while reset is held
  always @(negedge clk) begin
    if (!rstN) begin
      a_r1_quiet_in_reset: assert (!lkReady && !rsValid)
        else $error("R1: ready or result active during reset");
    end
  end

  // R2: every accepted lookup yields a result two edges later
  a_r2_result_follows: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && lkReady) |=> ##1 rsValid);

  // R2: no result without an acceptance two edges earlier
  a_r2_no_stray_result: assert property (@(posedge clk) disable iff (!rstN)
    rsValid |-> $past(lkValid && lkReady, 2));

  // R7, R5: insert beside a lookup of the same block shows the core
  a_r7_insert_visible: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && lkReady && updValid && !updOp && updAddr == lkAddr)
      |=> ##1 rsSharers[$past(updCore, 2)]);

  // R7, R6: full-mask clear beside a lookup of the same block removes the core
  a_r6_clear_visible: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && lkReady && updValid && updOp && (&updMask) && updAddr == lkAddr)
      |=> ##1 !rsSharers[$past(updCore, 2)]);

endmodule

bind dir_bloom_directory dir_bloom_checker #(
  .P(P), .K(K), .ADDR_W(ADDR_W)
) chk_i (.*);

// File: tb/dir_bloom_directory_tb_top.sv
module dir_bloom_directory_tb_top;

  localparam int P = 16, K = 4, ADDR_W = 48;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              lkValid = 1'b0;
  logic              lkReady;
  logic [ADDR_W-1:0] lkAddr = '0;
  logic              rsValid;
  logic [P-1:0]      rsSharers;
  logic              updValid = 1'b0;
  logic              updOp = 1'b0;
  logic [ADDR_W-1:0] updAddr = '0;
  logic [3:0]        updCore = '0;
  logic [K-1:0]      updMask = '0;

  always #2 clk = ~clk;  // 250 MHz

  dir_bloom_directory dut_i (.*);

  int nCmp = 0, nBad = 0, cyc = 0;
  bit done = 0;

  logic [15:0] mdl [4][256];
  bit          expV [4];
  logic [15:0] expVec [4];
  string       expReq [4];
  logic [37:0] tagPool [8];

  function automatic logic [3:0] bkt(int t, logic [37:0] tag);
    case (t)
      0: return tag[3:0];
      1: return tag[6:3];
      2: return tag[9:6];
      default: return tag[3:0] ^ tag[22:19];
    endcase
  endfunction

  function automatic logic [47:0] mk(logic [37:0] tag, logic [3:0] set);
    return {tag, set, 6'($urandom)};
  endfunction

  function automatic logic [15:0] predict(logic [47:0] a);
    logic [15:0] v = '1;
    for (int t = 0; t < 4; t++) v &= mdl[t][{a[9:6], bkt(t, a[47:10])}];
    return v;
  endfunction

  task automatic chk(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(bit lv, logic [47:0] la, bit uv, bit uop, logic [47:0] ua,
                      logic [3:0] uc, logic [3:0] um, string req);
    int slot;
    @(negedge clk);
    slot = cyc % 4;
    if (expV[slot]) begin
      chk(rsValid === 1'b1, {expReq[slot], " valid"}, 16'(rsValid), 16'h1);
      chk(rsSharers === expVec[slot], expReq[slot], rsSharers, expVec[slot]);
    end else if (rsValid !== 1'b0) begin
      chk(1'b0, "R2 stray", 16'(rsValid), 16'h0);
    end
    expV[slot] = 0;
    lkValid = lv; lkAddr = la;
    updValid = uv; updOp = uop; updAddr = ua; updCore = uc; updMask = um;
    if (uv) begin
      for (int t = 0; t < 4; t++) begin
        if (!uop)       mdl[t][{ua[9:6], bkt(t, ua[47:10])}][uc] = 1'b1;
        else if (um[t]) mdl[t][{ua[9:6], bkt(t, ua[47:10])}][uc] = 1'b0;
      end
    end
    if (lv && lkReady) begin
      expV[(cyc + 2) % 4]   = 1;
      expVec[(cyc + 2) % 4] = predict(la);
      expReq[(cyc + 2) % 4] = req;
    end
    cyc++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, '0, 0, 0, "R2");
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++; nCmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [37:0] tA, tB;
    logic [47:0] aA;
    void'($urandom(32'h1F2E3D4C));
    for (int t = 0; t < 4; t++) for (int e = 0; e < 256; e++) mdl[t][e] = '0;
    for (int s = 0; s < 4; s++) expV[s] = 0;
    for (int i = 0; i < 8; i++) tagPool[i] = {6'($urandom), $urandom};

    // R1: quiet during reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!lkReady && !rsValid, "R1 reset", {lkReady, rsValid}, 16'h0);
    end
    rstN = 1'b1;
    @(negedge clk);
    chk(lkReady === 1'b1, "R1 ready", 16'(lkReady), 16'h1);

    // R1: fresh table reads zero
    for (int i = 0; i < 4; i++) step(1, mk(tagPool[i], 4'(i)), 0, 0, '0, 0, 0, "R1 zero");
    idle(2);

    // R5: insert with zero mask, then lookup
    tA = tagPool[0]; aA = mk(tA, 4'd2);
    step(0, '0, 1, 0, aA, 4'd5, 4'h0, "R5");
    step(1, mk(tA, 4'd2), 0, 0, '0, 0, 0, "R5 insert");
    // R6: clear only table 0 drops the core from the AND
    step(0, '0, 1, 1, aA, 4'd5, 4'h1, "R6");
    step(1, aA, 0, 0, '0, 0, 0, "R6 partial clear");
    // R6: zero-mask clear leaves the bit
    step(0, '0, 1, 0, aA, 4'd7, 4'h0, "R6");
    step(0, '0, 1, 1, aA, 4'd7, 4'h0, "R6");
    step(1, aA, 0, 0, '0, 0, 0, "R6 zero mask");
    // R7: same-cycle insert seen, next-cycle insert not seen
    step(1, aA, 1, 0, aA, 4'd9, 4'hF, "R7 same cycle");
    step(1, aA, 0, 0, '0, 0, 0, "R7 before");
    step(0, '0, 1, 0, aA, 4'd11, 4'h0, "R7");
    step(1, aA, 1, 1, aA, 4'd9, 4'hF, "R7 same-cycle clear");
    // R8: same tag, other set stays clear
    step(1, mk(tA, 4'd3), 0, 0, '0, 0, 0, "R8 other set");
    // R4: tag bit 30 is read by no hash -> alias; bit 20 only by the fold
    tB = tA ^ (38'd1 << 30);
    step(1, mk(tB, 4'd2), 0, 0, '0, 0, 0, "R4 unused bit");
    tB = tA ^ (38'd1 << 20);
    step(1, mk(tB, 4'd2), 0, 0, '0, 0, 0, "R4 fold bit");
    // R2: back-to-back lookups
    for (int i = 0; i < 6; i++) step(1, mk(tagPool[i], 4'd2), 0, 0, '0, 0, 0, "R2 stream");
    idle(3);

    // R3: random mix over a small address pool
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 10) < 7, mk(tagPool[$urandom % 8], 4'($urandom % 4)),
           ($urandom % 2) == 1, ($urandom % 3) == 0,
           mk(tagPool[$urandom % 8], 4'($urandom % 4)),
           4'($urandom % P), 4'($urandom), "R3");
    end
    idle(4);
    finishRun();
  end

endmodule